// File: doc/BRIEF.md
# Low-Power SDRAM Power-Mode Sequencer

This block sits on the controller side of a low-power SDRAM and owns the command pins during start-up and during the three low-power states. After reset it holds the bus idle for a configurable boot window. It then closes every bank, runs a burst of auto-refresh cycles, and writes both the mode register and the extended register. Once that is done it raises a ready flag that tells the rest of the memory controller it may start traffic.

While ready, the block accepts requests to put the memory into precharge power-down, self refresh or deep power-down, and a wake request to bring it back. Every entry first closes all banks. Leaving deep power-down loses the array contents and the register settings, so the block replays the whole start-up sequence. All delays are clock counts taken from parameters. Read and write scheduling and periodic refresh timing are handled elsewhere.

Top module: `lpsdr_pwr_seq`

## Requirements
- R1: While reset is held, the pins carry NOP (CS, RAS, CAS, WE = 0,1,1,1) with CKE high, ready low and busy high. Ready stays low until the whole initialisation has finished.
- R2: After reset or a deep power-down exit, exactly T_INIT cycles of NOP with CKE high precede a precharge-all (code 0,0,1,0 with address bit 10 high).
- R3: N_AREF auto-refresh commands (code 0,0,0,1 with CKE high) follow. The first comes T_RP cycles after the precharge-all, and each later one comes T_RC cycles after the one before it.
- R4: T_RC cycles after the last initial refresh, a mode-register write (code 0,0,0,0) is issued with bank bits 00 and the address equal to the `mr_word` input.
- R5: T_MRD cycles after the mode-register write, an extended-register write is issued with the same code and bank bits 10. Its address bits [4:3] carry `emr_temp`, bits [2:0] carry the refresh coverage, and all higher bits are zero. Ready rises T_MRD cycles after this write.
- R6: Coverage codes 000 (all banks), 001 (half) and 010 (quarter) pass through unchanged. The reserved codes 011 to 111 are written as 000.
- R7: A power-down request issues a precharge-all. T_RP cycles later CKE falls with a NOP, and CKE then stays low with NOP. On wake, CKE rises with a NOP, and ready returns one cycle later.
- R8: A self-refresh request issues a precharge-all. T_RP cycles later the auto-refresh code appears with CKE falling. On wake, CKE rises with a NOP, and ready returns T_RC cycles after that.
- R9: A deep power-down request issues a precharge-all. T_RP cycles later the code 0,1,1,0 appears with CKE falling. On wake, CKE rises and the sequence of R2 to R5 is replayed, timed from the CKE rise.
- R10: Requests that arrive while the block is busy are held and served once it is ready. Among pending requests, deep power-down is served first, then self refresh, then power-down, and each request is served once.
- R11: A wake request that arrives while the block is ready has no effect: no command is issued, ready stays high, and the request is discarded.
- R12: Ack is a single-cycle pulse. It coincides with every CKE fall that enters a low-power state, and with the ready rise that ends a wake (not the first ready after reset). Ready and busy are never high together, and busy is low while resting in a low-power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk |
| req_pdown | input | 1 | Pulse: request precharge power-down |
| req_sref | input | 1 | Pulse: request self refresh |
| req_deep | input | 1 | Pulse: request deep power-down |
| req_wake | input | 1 | Pulse: request exit from the current low-power state |
| mr_word | input | ADDR_W | Value written to the mode register |
| emr_temp | input | 2 | Temperature range field (00 70 C, 01 45 C, 10 15 C, 11 85 C) |
| emr_cover | input | 3 | Self-refresh coverage field |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| ready | output | 1 | Memory initialised and idle |
| busy | output | 1 | A sequence is in progress |
| ack | output | 1 | One-cycle completion pulse for entries and wakes |

## Verification
The bench builds the block with T_INIT=40, T_RP=3, T_RC=5, T_MRD=2 and N_AREF=8. The short boot window makes full deep power-down round trips cheap, so many init replays fit in one run, each with a random mode word, temperature and coverage code, including the reserved ones. Three requests are pulsed in one cycle to exercise the priority order and the holding of pending work across a full replay. A power-down request pulsed during the boot window shows that requests are held while busy.

// File: rtl/lpsdr_pkg.sv
`timescale 1ns/1ps
package lpsdr_pkg;

  localparam int BA_W = 2;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = 4'b0111;
  localparam sd_cmd_t CMD_PALL = 4'b0010;
  localparam sd_cmd_t CMD_AREF = 4'b0001;
  localparam sd_cmd_t CMD_MRS  = 4'b0000;
  localparam sd_cmd_t CMD_DEEP = 4'b0110;

  typedef enum logic [1:0] {LP_PD = 2'd0, LP_SR = 2'd1, LP_DPD = 2'd2} lp_kind_t;

  typedef enum logic [3:0] {
    ST_WAKE, ST_BOOT_WAIT, ST_INIT_PALL, ST_INIT_PWAIT,
    ST_AREF, ST_AREF_WAIT, ST_MRS, ST_MRS_WAIT,
    ST_EMRS, ST_EMRS_WAIT, ST_IDLE, ST_LP_PALL,
    ST_LP_PWAIT, ST_LP_ENTER, ST_REST, ST_XWAIT
  } seq_state_t;

  // Reserved coverage codes fall back to full-array refresh.
  function automatic logic [2:0] cover_fix(input logic [2:0] c);
    return (c inside {3'b000, 3'b001, 3'b010}) ? c : 3'b000;
  endfunction

endpackage

// File: rtl/lpsdr_wait_timer.sv
`timescale 1ns/1ps
module lpsdr_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpsdr_req_hold.sv
`timescale 1ns/1ps
module lpsdr_req_hold #(
  parameter int N_KIND = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_KIND-1:0] req_in,
  input  logic [N_KIND-1:0] req_clr,
  input  logic              wake_in,
  input  logic              wake_clr,
  output logic [N_KIND-1:0] pend,
  output logic              pend_wake
);
  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       pend[k] <= 1'b0;
      else if (req_in[k])               pend[k] <= 1'b1;
      else if (req_clr[k])              pend[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_wake <= 1'b0;
    else if (wake_in)  pend_wake <= 1'b1;
    else if (wake_clr) pend_wake <= 1'b0;
  end
endmodule

// File: rtl/lpsdr_pin_reg.sv
`timescale 1ns/1ps
module lpsdr_pin_reg
  import lpsdr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sd_cmd_t           cmd_d,
  input  logic              cke_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              rdy_d,
  input  logic              bsy_d,
  input  logic              ack_d,
  output sd_cmd_t           cmd_q,
  output logic              cke_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rdy_q,
  output logic              bsy_q,
  output logic              ack_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      cke_q  <= 1'b1;
      ba_q   <= '0;
      addr_q <= '0;
      rdy_q  <= 1'b0;
      bsy_q  <= 1'b1;
      ack_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      cke_q  <= cke_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      rdy_q  <= rdy_d;
      bsy_q  <= bsy_d;
      ack_q  <= ack_d;
    end
  end
endmodule

// File: rtl/lpsdr_pwr_seq.sv
`timescale 1ns/1ps
module lpsdr_pwr_seq
  import lpsdr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int T_INIT = 25000,
  parameter int T_RP   = 3,
  parameter int T_RC   = 9,
  parameter int T_MRD  = 2,
  parameter int N_AREF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_pdown,
  input  logic              req_sref,
  input  logic              req_deep,
  input  logic              req_wake,
  input  logic [ADDR_W-1:0] mr_word,
  input  logic [1:0]        emr_temp,
  input  logic [2:0]        emr_cover,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              ready,
  output logic              busy,
  output logic              ack
);
  // All delays must be at least 2 cycles; each wait state lasts (T - 1) cycles.
  localparam int M1    = (T_INIT > T_RC) ? T_INIT : T_RC;
  localparam int M2    = (M1 > T_RP) ? M1 : T_RP;
  localparam int MAXT  = (M2 > T_MRD) ? M2 : T_MRD;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam int AR_W  = $clog2(N_AREF + 1);
  localparam int N_KIND = 3;

  seq_state_t       st_q, st_d;
  lp_kind_t         kind_q, kind_d;
  logic [AR_W-1:0]  aref_q;
  logic             aref_clr, aref_inc;
  logic             exit_q, exit_set, exit_clr;

  logic             t_load, t_done;
  logic [CNT_W-1:0] t_val;

  logic [N_KIND-1:0] pend, req_clr;
  logic              pend_wake, wake_clr;

  sd_cmd_t           cmd_d, cmd_q;
  logic              cke_d, rdy_d, bsy_d, ack_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  lpsdr_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  lpsdr_req_hold #(.N_KIND(N_KIND)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .req_in({req_deep, req_sref, req_pdown}), .req_clr(req_clr),
    .wake_in(req_wake), .wake_clr(wake_clr),
    .pend(pend), .pend_wake(pend_wake)
  );

  // Next-state and command decode
  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    cmd_d    = CMD_NOP;
    cke_d    = 1'b1;
    ba_d     = '0;
    addr_d   = '0;
    rdy_d    = 1'b0;
    bsy_d    = 1'b1;
    ack_d    = 1'b0;
    t_load   = 1'b0;
    t_val    = '0;
    aref_clr = 1'b0;
    aref_inc = 1'b0;
    exit_set = 1'b0;
    exit_clr = 1'b0;
    req_clr  = '0;
    wake_clr = 1'b0;
    unique case (st_q)
      ST_WAKE: begin
        if (kind_q == LP_DPD) begin
          t_load = 1'b1; t_val = CNT_W'(T_INIT - 2); st_d = ST_BOOT_WAIT;
        end else if (kind_q == LP_SR) begin
          t_load = 1'b1; t_val = CNT_W'(T_RC - 2);   st_d = ST_XWAIT;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_BOOT_WAIT:  if (t_done) st_d = ST_INIT_PALL;
      ST_INIT_PALL: begin
        cmd_d = CMD_PALL; addr_d[10] = 1'b1; aref_clr = 1'b1;
        t_load = 1'b1; t_val = CNT_W'(T_RP - 2); st_d = ST_INIT_PWAIT;
      end
      ST_INIT_PWAIT: if (t_done) st_d = ST_AREF;
      ST_AREF: begin
        cmd_d = CMD_AREF; aref_inc = 1'b1;
        t_load = 1'b1; t_val = CNT_W'(T_RC - 2); st_d = ST_AREF_WAIT;
      end
      ST_AREF_WAIT:
        if (t_done) st_d = (aref_q == AR_W'(N_AREF)) ? ST_MRS : ST_AREF;
      ST_MRS: begin
        cmd_d = CMD_MRS; addr_d = mr_word;
        t_load = 1'b1; t_val = CNT_W'(T_MRD - 2); st_d = ST_MRS_WAIT;
      end
      ST_MRS_WAIT:   if (t_done) st_d = ST_EMRS;
      ST_EMRS: begin
        cmd_d = CMD_MRS; ba_d = 2'b10;
        addr_d[4:3] = emr_temp; addr_d[2:0] = cover_fix(emr_cover);
        t_load = 1'b1; t_val = CNT_W'(T_MRD - 2); st_d = ST_EMRS_WAIT;
      end
      ST_EMRS_WAIT:  if (t_done) st_d = ST_IDLE;
      ST_IDLE: begin
        rdy_d = 1'b1; bsy_d = 1'b0; ack_d = exit_q; exit_clr = 1'b1;
        wake_clr = 1'b1;
        if (pend != '0) begin
          if (pend[2])      kind_d = LP_DPD;
          else if (pend[1]) kind_d = LP_SR;
          else              kind_d = LP_PD;
          st_d = ST_LP_PALL;
        end
      end
      ST_LP_PALL: begin
        cmd_d = CMD_PALL; addr_d[10] = 1'b1;
        t_load = 1'b1; t_val = CNT_W'(T_RP - 2); st_d = ST_LP_PWAIT;
      end
      ST_LP_PWAIT:   if (t_done) st_d = ST_LP_ENTER;
      ST_LP_ENTER: begin
        cke_d = 1'b0; ack_d = 1'b1;
        req_clr = N_KIND'(1) << kind_q;
        cmd_d = (kind_q == LP_DPD) ? CMD_DEEP :
                (kind_q == LP_SR)  ? CMD_AREF : CMD_NOP;
        st_d = ST_REST;
      end
      ST_REST: begin
        cke_d = 1'b0; bsy_d = 1'b0;
        if (pend_wake) begin
          wake_clr = 1'b1; exit_set = 1'b1; st_d = ST_WAKE;
        end
      end
      ST_XWAIT:      if (t_done) st_d = ST_IDLE;
      default:       st_d = ST_WAKE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAKE;
      kind_q <= LP_DPD;
      aref_q <= '0;
      exit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      if (aref_clr)      aref_q <= '0;
      else if (aref_inc) aref_q <= aref_q + 1'b1;
      if (exit_set)      exit_q <= 1'b1;
      else if (exit_clr) exit_q <= 1'b0;
    end
  end

  lpsdr_pin_reg #(.ADDR_W(ADDR_W)) u_pins (
    .clk(clk), .rst_n(rst_n),
    .cmd_d(cmd_d), .cke_d(cke_d), .ba_d(ba_d), .addr_d(addr_d),
    .rdy_d(rdy_d), .bsy_d(bsy_d), .ack_d(ack_d),
    .cmd_q(cmd_q), .cke_q(sd_cke), .ba_q(sd_ba), .addr_q(sd_addr),
    .rdy_q(ready), .bsy_q(busy), .ack_q(ack)
  );

  assign sd_cs_n  = cmd_q.cs_n;
  assign sd_ras_n = cmd_q.ras_n;
  assign sd_cas_n = cmd_q.cas_n;
  assign sd_we_n  = cmd_q.we_n;
endmodule

// File: rtl/lpsdr_seq_chk.sv
`timescale 1ns/1ps
module lpsdr_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [1:0]        sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              ready,
  input logic              busy,
  input logic              ack
);
  logic [3:0] pin_code;
  assign pin_code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R12: ready and busy are exclusive
  a_r12_ready_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && busy));

  // R12: ack lasts one cycle
  a_r12_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R12: every entry into a low-power state is acknowledged
  a_r12_entry_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cke) |-> ack);

  // R7: while resting with CKE low, only NOP is driven
  a_r7_rest_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cke && $past(sd_cke) == 1'b0) |-> (pin_code == 4'b0111));

  // R7: the first cycle after CKE rises carries NOP
  a_r7_wake_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cke) |-> (pin_code == 4'b0111));

  // R1: ready only with the memory clock enabled
  a_r1_ready_cke: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> sd_cke);

  // R5: a register write is followed by NOP (tMRD of at least 2)
  a_r5_mrs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_code == 4'b0000) |=> (pin_code == 4'b0111));

  // R6: extended write never carries a reserved coverage code or high bits
  a_r6_emr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_code == 4'b0000 && sd_ba == 2'b10) |->
      (sd_addr[2:0] <= 3'd2 && sd_addr[ADDR_W-1:5] == '0));
endmodule

bind lpsdr_pwr_seq lpsdr_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_ba(sd_ba), .sd_addr(sd_addr), .ready(ready), .busy(busy), .ack(ack)
);

// File: tb/test_lpsdr_pwr_seq.sv
`timescale 1ns/1ps
module test_lpsdr_pwr_seq;
  localparam int ADDR_W = 12;
  localparam int T_INIT = 40;
  localparam int T_RP   = 3;
  localparam int T_RC   = 5;
  localparam int T_MRD  = 2;
  localparam int N_AREF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_pdown, req_sref, req_deep, req_wake;
  logic [ADDR_W-1:0] mr_word;
  logic [1:0] emr_temp;
  logic [2:0] emr_cover;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, ready, busy, ack;
  logic [1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  lpsdr_pwr_seq #(.ADDR_W(ADDR_W), .T_INIT(T_INIT), .T_RP(T_RP), .T_RC(T_RC),
                  .T_MRD(T_MRD), .N_AREF(N_AREF)) i_lpsdr_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_pdown(req_pdown), .req_sref(req_sref),
    .req_deep(req_deep), .req_wake(req_wake), .mr_word(mr_word),
    .emr_temp(emr_temp), .emr_cover(emr_cover), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .ready(ready), .busy(busy), .ack(ack)
  );

  int checks = 0, failures = 0, cyc = 0, overlap = 0, rdy_hits = 0;
  int s_cyc;
  logic [3:0] s_cmd;
  logic s_cke, s_rdy, s_bsy, s_ack, ev_cke, ev_rdy;
  logic [1:0] s_ba;
  logic [ADDR_W-1:0] s_addr;
  logic p_cke = 1'b1, p_rdy = 1'b0, p_ack = 1'b0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int exp_emr(input int t, input int c);
    return (t << 3) | ((c > 2) ? 0 : c);
  endfunction

  function automatic int entry_code(input int k);
    return (k == 2) ? 6 : (k == 1) ? 1 : 7;
  endfunction

  function automatic string ktag(input int k);
    return (k == 2) ? "R9" : (k == 1) ? "R8" : "R7";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    s_cyc = cyc; s_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    s_cke = sd_cke; s_rdy = ready; s_bsy = busy; s_ack = ack;
    s_ba = sd_ba; s_addr = sd_addr;
    ev_cke = (s_cke !== p_cke);
    ev_rdy = s_rdy && !p_rdy;
    if (s_rdy && s_bsy) overlap++;
    if (s_ack && p_ack) overlap++;
    if (s_rdy) rdy_hits++;
    p_cke = s_cke; p_rdy = s_rdy; p_ack = s_ack;
  endtask

  task automatic wait_cmd(output int c);
    int n = 0;
    do begin step(); n++; end
    while (!(s_cmd != 4'd7 || ev_cke) && n < 3000);
    if (n >= 3000) chk(1'b0, "command timeout", n, 0);
    c = s_cyc;
  endtask

  task automatic wait_ready(output int c);
    int n = 0;
    do begin step(); n++; end
    while (!ev_rdy && n < 3000);
    if (n >= 3000) chk(1'b0, "ready timeout", n, 0);
    c = s_cyc;
  endtask

  task automatic pulse(input logic [3:0] m);
    {req_wake, req_deep, req_sref, req_pdown} = m;
    step();
    {req_wake, req_deep, req_sref, req_pdown} = 4'b0;
  endtask

  task automatic check_init(input int start, input bit exp_ack,
                            input int temp, input int cov, input int mr);
    int c, last;
    rdy_hits = 0;
    wait_cmd(c);
    chk(s_cmd == 4'd2 && s_addr[10], "R2 precharge-all after boot", s_cmd, 2);
    chk(c - start == T_INIT, "R2 boot NOP window", c - start, T_INIT);
    last = c;
    for (int i = 0; i < N_AREF; i++) begin
      wait_cmd(c);
      chk(s_cmd == 4'd1 && s_cke, "R3 auto-refresh code", s_cmd, 1);
      chk(c - last == ((i == 0) ? T_RP : T_RC), "R3 refresh spacing",
          c - last, (i == 0) ? T_RP : T_RC);
      last = c;
    end
    wait_cmd(c);
    chk(s_cmd == 4'd0 && s_ba == 2'd0, "R4 mode write bank", s_ba, 0);
    chk(s_addr == mr[ADDR_W-1:0], "R4 mode word", s_addr, mr);
    chk(c - last == T_RC, "R4 gap after refresh", c - last, T_RC);
    last = c;
    wait_cmd(c);
    chk(s_cmd == 4'd0 && s_ba == 2'd2, "R5 extended bank", s_ba, 2);
    chk(s_addr == exp_emr(temp, cov), (cov > 2) ? "R6 reserved coverage" : "R5 extended word",
        s_addr, exp_emr(temp, cov));
    chk(c - last == T_MRD, "R5 tMRD gap", c - last, T_MRD);
    last = c;
    chk(rdy_hits == 0, "R1 ready low during init", rdy_hits, 0);
    wait_ready(c);
    chk(c - last == T_MRD, "R5 ready after extended write", c - last, T_MRD);
    chk(s_ack == exp_ack, "R12 ack with ready", s_ack, exp_ack);
  endtask

  task automatic enter(input int k, input bit do_pulse);
    int c, last;
    if (do_pulse) pulse(4'b0001 << k);
    wait_cmd(c);
    chk(s_cmd == 4'd2 && s_addr[10] && s_cke, {ktag(k), " precharge before entry"}, s_cmd, 2);
    last = c;
    wait_cmd(c);
    chk(s_cmd == entry_code(k), {ktag(k), " entry code"}, s_cmd, entry_code(k));
    chk(ev_cke && !s_cke, {ktag(k), " CKE falls on entry"}, s_cke, 0);
    chk(c - last == T_RP, {ktag(k), " entry after tRP"}, c - last, T_RP);
    chk(s_ack && !s_rdy, "R12 entry ack", s_ack, 1);
    repeat (4) step();
    chk(!s_cke && !s_bsy && s_cmd == 4'd7, {ktag(k), " rest holds CKE low"}, s_cke, 0);
  endtask

  task automatic leave(input int k, input int temp, input int cov, input int mr);
    int c, r;
    emr_temp = temp[1:0]; emr_cover = cov[2:0]; mr_word = mr[ADDR_W-1:0];
    pulse(4'b1000);
    wait_cmd(c);
    chk(s_cke && s_cmd == 4'd7, {ktag(k), " wake CKE rise with NOP"}, s_cmd, 7);
    if (k == 2) begin
      check_init(c, 1'b1, temp, cov, mr);
    end else begin
      wait_ready(r);
      chk(r - c == ((k == 0) ? 1 : T_RC), {ktag(k), " ready after wake"},
          r - c, (k == 0) ? 1 : T_RC);
      chk(s_ack, "R12 exit ack", s_ack, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed, quiet;
    seed = $urandom(32'd7731);
    rst_n = 1'b0;
    {req_wake, req_deep, req_sref, req_pdown} = 4'b0;
    mr_word = 12'h032; emr_temp = 2'b01; emr_cover = 3'b001;
    repeat (3) step();
    chk(s_cmd == 4'd7 && s_cke && !s_rdy && s_bsy, "R1 reset pins", s_cmd, 7);
    rst_n = 1'b1;
    repeat (4) step();
    // R10: power-down request made during initialisation is held
    pulse(4'b0001);
    check_init(1, 1'b0, 1, 1, 12'h032);
    enter(0, 1'b0);
    leave(0, 0, 0, 0);

    // R11: wake while ready does nothing
    pulse(4'b1000);
    quiet = 0;
    repeat (10) begin
      step();
      if (s_cmd != 4'd7 || ev_cke || !s_rdy) quiet++;
    end
    chk(quiet == 0, "R11 wake ignored while ready", quiet, 0);
    enter(0, 1'b1);
    leave(0, 0, 0, 0);

    // R10: three requests at once, served deep, self, power-down
    pulse(4'b0111);
    enter(2, 1'b0);
    leave(2, 2, 5, 12'h5a3);
    enter(1, 1'b0);
    leave(1, 0, 0, 0);
    enter(0, 1'b0);
    leave(0, 0, 0, 0);

    // R6: every reserved coverage code, then random rounds
    for (int rc = 3; rc < 8; rc++) begin
      enter(2, 1'b1);
      leave(2, 3, rc, 12'h021 + rc);
    end
    for (int i = 0; i < 8; i++) begin
      int k, t, cv, mw;
      k = $urandom % 3; t = $urandom % 4; cv = $urandom % 8; mw = $urandom % 4096;
      enter(k, 1'b1);
      leave(k, t, cv, mw);
    end

    chk(overlap == 0, "R12 ready/busy exclusive and ack single", overlap, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule